// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the processor-facing side of a serial port. It decodes a small read/write bus into six word-aligned 32-bit registers, holds the control, threshold and baud settings, and drives them to the serial transmitter, receiver and baud generator. Those sit outside the block. It contains a transmit FIFO and a receive FIFO, both parameterised in depth, and talks to the shift logic through valid/ready style handshakes.

Status combines live FIFO conditions, the transmitter's busy line and three sticky error flags. The clear-errors and FIFO-flush controls are level bits: they act for as long as they read 1, and software writes them back to 0. One level interrupt output combines a receive-fill condition and a transmit-drain condition. Each compares a FIFO count against its own 8-bit threshold from the threshold register.

Top module: `uart_regfile`

## Requirements
- R1: After reset, control, threshold and baud read 0, status reads 0x0050_0000 (bit 20 receive empty and bit 22 transmit empty set), `irq` is 0 and `tx_valid` is 0.
- R2: Control at byte offset 0x08 and baud at 0x14 read back the full 32-bit value written and appear on `ctrl_out` and `baud_out`. The threshold register at 0x10 keeps bits 15:0 and reads 0 in bits 31:16.
- R3: A write to offset 0x00 queues bits 7:0 of the write data in the transmit FIFO. While control bit 12 is 1 and the FIFO is not empty, `tx_valid` is 1 and `tx_data` shows the oldest byte. Each cycle with `tx_valid` and `tx_ready` both high removes that byte. Bytes leave in write order.
- R4: When the transmit FIFO holds DEPTH entries, status bit 21 is 1. A further write is dropped and sets sticky status bit 18.
- R5: With control bit 13 set, each `rx_valid` cycle stores `rx_data` in the receive FIFO. With bit 13 clear, arrivals are ignored. A read of offset 0x04 returns the oldest byte in bits 7:0 and removes it. A read while status bit 20 (receive empty) is 1 returns 0 and removes nothing.
- R6: An arrival accepted under control bit 13 sets sticky status bit 16 if `rx_parity_err` is high and sticky bit 17 if `rx_frame_err` is high.
- R7: While control bit 24 reads 1, status bits 16 to 18 read 0 and no error can set them. The bit stays 1 until software writes 0.
- R8: While control bit 22 is 1, the transmit FIFO is held empty, `tx_valid` is 0 and writes to 0x00 are ignored. While bit 23 is 1, the receive FIFO is held empty and arrivals are ignored.
- R9: With control bit 27 set, `irq` is 1 while the receive FIFO count is at least threshold bits 7:0.
- R10: With control bit 28 set, `irq` is 1 while the transmit FIFO count is below threshold bits 15:8. With bits 27 and 28 both clear, `irq` is 0.
- R11: Status bit 25 follows `tx_busy`. The transmitter is fully idle when bit 22 is 1 and bit 25 is 0.
- R12: An arrival while the receive FIFO holds DEPTH entries is dropped and leaves the stored bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address; bits 4:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Transmitter takes the byte |
| tx_busy | input | 1 | Transmitter is shifting |
| rx_valid | input | 1 | Received byte present |
| rx_data | input | 8 | Received byte |
| rx_parity_err | input | 1 | Parity error on this byte |
| rx_frame_err | input | 1 | Frame error on this byte |
| ctrl_out | output | 32 | Control register to serial logic |
| baud_out | output | 32 | Baud configuration to baud generator |
| irq | output | 1 | Level interrupt |

## Verification
A wrong FIFO pointer or count shows at the ports as soon as the next byte is read. It can appear as a reordered or repeated byte on `tx_data` or in receive reads, a full or empty status bit that disagrees with the number of bytes pushed, or an interrupt level that flips at the wrong fill. Sticky error state that is set or cleared wrongly shows in the next status read. A flush or clear control that does not hold is caught by an arrival or write made while it is asserted, followed by a status read one cycle later.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  input  logic        tx_busy,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_parity_err,
  input  logic        rx_frame_err,
  output logic [31:0] ctrl_out,
  output logic [31:0] baud_out,
  output logic        irq
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [31:0]   ctrl_q, baud_q;
  logic [15:0]   thr_q;
  logic [2:0]    err_q;
  logic [7:0]    tx_mem [DEPTH];
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  wire [2:0] idx      = bus_addr[4:2];
  wire       wr_tx    = bus_sel & bus_wr & (idx == 3'd0);
  wire       rd_rx    = bus_sel & ~bus_wr & (idx == 3'd1);
  wire       tx_full  = (tx_cnt == CW'(DEPTH));
  wire       tx_empty = (tx_cnt == '0);
  wire       rx_full  = (rx_cnt == CW'(DEPTH));
  wire       rx_empty = (rx_cnt == '0);
  wire       tx_flush = ctrl_q[22];
  wire       rx_flush = ctrl_q[23];
  wire       tx_push  = wr_tx & ~tx_flush & ~tx_full;
  wire       tx_ovf   = wr_tx & ~tx_flush & tx_full;
  wire       tx_pop   = tx_valid & tx_ready;
  wire       rx_take  = rx_valid & ctrl_q[13] & ~rx_flush;
  wire       rx_push  = rx_take & ~rx_full;
  wire       rx_pop   = rd_rx & ~rx_empty;

  assign tx_valid = ctrl_q[12] & ~tx_flush & ~tx_empty;
  assign tx_data  = tx_mem[tx_rp];
  assign ctrl_out = ctrl_q;
  assign baud_out = baud_q;
  assign irq = (ctrl_q[27] & (32'(rx_cnt) >= 32'(thr_q[7:0]))) |
               (ctrl_q[28] & (32'(tx_cnt) <  32'(thr_q[15:8])));

  wire [31:0] status = {6'b0, tx_busy, 2'b0, tx_empty, tx_full, rx_empty, 1'b0, err_q, 16'b0};

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (idx)
        3'd1:    bus_rdata = rx_empty ? 32'b0 : {24'b0, rx_mem[rx_rp]};
        3'd2:    bus_rdata = ctrl_q;
        3'd3:    bus_rdata = status;
        3'd4:    bus_rdata = {16'b0, thr_q};
        3'd5:    bus_rdata = baud_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      baud_q <= '0;
      thr_q  <= '0;
      err_q  <= '0;
    end else begin
      if (bus_sel && bus_wr && idx == 3'd2) ctrl_q <= bus_wdata;
      if (bus_sel && bus_wr && idx == 3'd4) thr_q  <= bus_wdata[15:0];
      if (bus_sel && bus_wr && idx == 3'd5) baud_q <= bus_wdata;
      if (ctrl_q[24]) err_q <= '0;
      else err_q <= err_q | {tx_ovf, rx_take & rx_frame_err, rx_take & rx_parity_err};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else if (tx_flush) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (tx_pop)  tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_push) - CW'(tx_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else if (rx_flush) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop)  rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];
    if (rx_push) rx_mem[rx_wp] <= rx_data;
  end
endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_sel,
  input logic                       bus_wr,
  input logic [4:0]                 bus_addr,
  input logic [31:0]                bus_rdata,
  input logic                       tx_valid,
  input logic                       tx_ready,
  input logic                       irq,
  input logic [31:0]                ctrl_q,
  input logic [2:0]                 err_q,
  input logic [$clog2(DEPTH+1)-1:0] tx_cnt,
  input logic [$clog2(DEPTH+1)-1:0] rx_cnt
);
  localparam int CW = $clog2(DEPTH + 1);

  p_clear_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[24] |=> err_q == 3'b0);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr[4:2] == 3'd0 && tx_cnt == CW'(DEPTH) &&
     !ctrl_q[22] && !ctrl_q[24] && !(tx_valid && tx_ready))
    |=> (tx_cnt == CW'(DEPTH)) && err_q[2]);

  p_tx_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[22] |=> tx_cnt == '0);

  p_rx_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[23] |=> rx_cnt == '0);

  p_tx_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[12] |-> !tx_valid);

  p_irq_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[27] && !ctrl_q[28]) |-> !irq);

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[4:2] == 3'd1 && rx_cnt == '0) |-> bus_rdata == 32'b0);

  p_rx_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_cnt <= CW'(DEPTH));
endmodule

bind uart_regfile uart_regfile_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
  .tx_ready(tx_ready), .irq(irq), .ctrl_q(ctrl_q), .err_q(err_q),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/uart_regfile_tb.sv
module uart_regfile_tb;
  localparam int D = 16;
  localparam logic [4:0] A_TX = 5'h00, A_RX = 5'h04, A_CTL = 5'h08,
                         A_ST = 5'h0C, A_THR = 5'h10, A_BAUD = 5'h14;

  logic clk = 0, rst_n = 0;
  logic bus_sel = 0, bus_wr = 0;
  logic [4:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic tx_valid, tx_ready = 0, tx_busy = 0;
  logic [7:0] tx_data, rx_data = '0;
  logic rx_valid = 0, rx_parity_err = 0, rx_frame_err = 0;
  logic [31:0] ctrl_out, baud_out;
  logic irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0] txq[$], rxq[$];
  logic m_par = 0, m_frm = 0, m_ovf = 0;

  always #5 clk = ~clk;

  uart_regfile #(.DEPTH(D)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_busy(tx_busy), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_parity_err(rx_parity_err), .rx_frame_err(rx_frame_err), .ctrl_out(ctrl_out),
    .baud_out(baud_out), .irq(irq));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_sel = 0;
  endtask

  task automatic rx_put(input logic [7:0] d, input logic p, input logic f);
    @(negedge clk); rx_valid = 1; rx_data = d; rx_parity_err = p; rx_frame_err = f;
    @(negedge clk); rx_valid = 0; rx_parity_err = 0; rx_frame_err = 0;
  endtask

  task automatic tx_take();
    @(negedge clk); tx_ready = 1;
    @(negedge clk); tx_ready = 0;
  endtask

  function automatic logic [31:0] exp_status();
    logic [31:0] s = '0;
    s[16] = m_par; s[17] = m_frm; s[18] = m_ovf;
    s[20] = (rxq.size() == 0);
    s[21] = (txq.size() == D);
    s[22] = (txq.size() == 0);
    s[25] = tx_busy;
    return s;
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(A_ST, r);   check("R1 status", r, 32'h0050_0000);
    rd(A_CTL, r);  check("R1 ctrl", r, 0);
    rd(A_THR, r);  check("R1 thr", r, 0);
    rd(A_BAUD, r); check("R1 baud", r, 0);
    check("R1 irq", irq, 0);
    check("R1 tx_valid", tx_valid, 0);

    // R2 register map
    wr(A_CTL, 32'h0055_0003); rd(A_CTL, r); check("R2 ctrl rb", r, 32'h0055_0003);
    check("R2 ctrl_out", ctrl_out, 32'h0055_0003);
    wr(A_CTL, 0);
    wr(A_THR, 32'hFFFF_FFFF); rd(A_THR, r); check("R2 thr rb", r, 32'h0000_FFFF);
    wr(A_THR, 0);
    wr(A_BAUD, 32'h80AB_CDEF); rd(A_BAUD, r); check("R2 baud rb", r, 32'h80AB_CDEF);
    check("R2 baud_out", baud_out, 32'h80AB_CDEF);

    // R3 transmit path
    wr(A_TX, 32'h0000_01A5); wr(A_TX, 32'h3C);
    #1 check("R3 gated off", tx_valid, 0);
    wr(A_CTL, 32'h1000);
    #1 check("R3 valid", tx_valid, 1); check("R3 first", tx_data, 8'hA5);
    tx_take();
    #1 check("R3 second", tx_data, 8'h3C);
    tx_take();
    #1 check("R3 drained", tx_valid, 0);
    rd(A_ST, r); check("R3 empty", r[22], 1);

    // R4 full and overflow
    wr(A_CTL, 0);
    for (int i = 0; i < D; i++) wr(A_TX, i);
    rd(A_ST, r); check("R4 full", r[21], 1); check("R4 no ovf yet", r[18], 0);
    wr(A_TX, 32'hEE);
    rd(A_ST, r); check("R4 ovf", r[18], 1);
    wr(A_CTL, 32'h1000);
    for (int i = 0; i < D; i++) begin
      #1 check("R4 order", tx_data, i);
      tx_take();
    end
    #1 check("R4 dropped", tx_valid, 0);
    rd(A_ST, r); check("R4 sticky", r[18], 1);

    // R7 clear held, R6 error capture
    wr(A_CTL, 32'h0100_2000);
    rd(A_ST, r); check("R7 cleared", r[18:16], 0);
    rx_put(8'h51, 1, 1);
    rd(A_ST, r); check("R7 held", r[18:16], 0);
    rd(A_CTL, r); check("R7 stays", r[24], 1);
    wr(A_CTL, 32'h2000);
    rx_put(8'h52, 1, 0);
    rd(A_ST, r); check("R6 parity", r[18:16], 3'b001);
    rx_put(8'h53, 0, 1);
    rd(A_ST, r); check("R6 frame", r[18:16], 3'b011);
    rd(A_RX, r); check("R6 d0", r, 8'h51);
    rd(A_RX, r); check("R6 d1", r, 8'h52);
    rd(A_RX, r); check("R6 d2", r, 8'h53);
    wr(A_CTL, 32'h0100_0000); wr(A_CTL, 0);

    // R5 receive path
    rx_put(8'h77, 0, 0);
    rd(A_ST, r); check("R5 ignored", r[20], 1);
    rd(A_RX, r); check("R5 empty read", r, 0);
    wr(A_CTL, 32'h2000);
    rx_put(8'h11, 0, 0); rx_put(8'h22, 0, 0);
    rd(A_RX, r); check("R5 first", r, 8'h11);
    rd(A_RX, r); check("R5 second", r, 8'h22);
    rd(A_RX, r); check("R5 empty", r, 0);
    rd(A_ST, r); check("R5 rx empty", r[20], 1);

    // R12 receive full drop
    for (int i = 0; i <= D; i++) rx_put(8'h80 + 8'(i), 0, 0);
    for (int i = 0; i < D; i++) begin
      rd(A_RX, r); check("R12 order", r, 8'h80 + 8'(i));
    end
    rd(A_RX, r); check("R12 dropped", r, 0);

    // R8 flush controls
    rx_put(8'h01, 0, 0); rx_put(8'h02, 0, 0);
    wr(A_TX, 32'h09); wr(A_TX, 32'h0A);
    wr(A_CTL, 32'h00C0_3000);
    #1 check("R8 tx_valid", tx_valid, 0);
    wr(A_TX, 32'h0B); rx_put(8'h03, 0, 0);
    rd(A_ST, r); check("R8 both empty", {r[22], r[20]}, 2'b11);
    wr(A_CTL, 32'h3000);
    #1 check("R8 tx stays empty", tx_valid, 0);
    rd(A_RX, r); check("R8 rx stays empty", r, 0);
    rd(A_ST, r); check("R8 no ovf", r[18], 0);

    // R9 receive interrupt
    wr(A_THR, 32'h0002); wr(A_CTL, 32'h0800_2000);
    #1 check("R9 idle", irq, 0);
    rx_put(8'h41, 0, 0); #1 check("R9 one", irq, 0);
    rx_put(8'h42, 0, 0); #1 check("R9 two", irq, 1);
    rd(A_RX, r); #1 check("R9 below", irq, 0);
    rd(A_RX, r);

    // R10 transmit interrupt
    wr(A_THR, 32'h0300); wr(A_CTL, 32'h1000_0000);
    #1 check("R10 empty", irq, 1);
    wr(A_TX, 1); wr(A_TX, 2); #1 check("R10 two", irq, 1);
    wr(A_TX, 3); #1 check("R10 three", irq, 0);
    wr(A_CTL, 32'h0040_0000);
    #1 check("R10 disabled", irq, 0);
    wr(A_CTL, 0); wr(A_THR, 0);

    // R11 busy flag
    tx_busy = 1;
    rd(A_ST, r); check("R11 busy", {r[25], r[22]}, 2'b11);
    tx_busy = 0;
    rd(A_ST, r); check("R11 idle", {r[25], r[22]}, 2'b01);

    // random phase
    wr(A_CTL, 32'h0100_0000);
    wr(A_CTL, 32'h3000);
    void'($urandom(1234));
    for (int it = 0; it < 600; it++) begin
      int op = $urandom_range(0, 4);
      logic [7:0] d = 8'($urandom);
      case (op)
        0: begin
          wr(A_TX, {24'($urandom), d});
          if (txq.size() == D) m_ovf = 1; else txq.push_back(d);
        end
        1: begin
          #1 check("R3 rand valid", tx_valid, txq.size() != 0);
          if (txq.size() != 0) begin
            check("R3 rand data", tx_data, txq[0]);
            tx_take();
            void'(txq.pop_front());
          end
        end
        2: begin
          logic p = ($urandom_range(0, 7) == 0);
          logic f = ($urandom_range(0, 7) == 0);
          rx_put(d, p, f);
          m_par |= p; m_frm |= f;
          if (rxq.size() < D) rxq.push_back(d);
        end
        3: begin
          rd(A_RX, r);
          if (rxq.size() == 0) check("R5 rand empty", r, 0);
          else begin
            check("R5 rand data", r, rxq[0]);
            void'(rxq.pop_front());
          end
        end
        default: begin
          rd(A_ST, r); check("R6 rand status", r, exp_status());
        end
      endcase
    end
    finish_run();
  end
endmodule